// File: doc/BRIEF.md
# LCD Sync and Active-Window Timing Generator

This block produces the horizontal sync, vertical sync and data-valid window for a 320x240 TFT panel driven over a parallel pixel bus. All timing is counted in bus clock ticks, and a pixel takes one, two or three ticks depending on how the bus is used (16-bit RGB565, 8-bit RGB565 or 8-bit RGB888). Every horizontal quantity is scaled by that clocks-per-pixel factor, and the first valid data tick of each line is pushed later by a small mode-dependent correction that makes up for the delay of the pixel packing logic downstream.

A frame is 244 lines: 2 blanking lines, 240 visible lines, then 2 more blanking lines. Both sync outputs are active low. The current line and column counters are exported so that a pixel fetch unit can follow the raster. When the enable input is low the generator rests with counters at zero and syncs inactive; a change of the mode input is taken up only while idle or at the start of a new frame, never within a frame.

Top module: `lcd_raster_timer`

## Requirements
- R1: While `en` is low (or in reset), `col` and `line` are 0, `hsync_n` and `vsync_n` are 1 and `de` is 0.
- R2: The active mode sets clocks-per-pixel K and correction C: mode 0 gives K=1, C=0; mode 1 gives K=2, C=3; mode 2 gives K=3, C=5; mode 3 behaves as mode 0.
- R3: While running, `col` counts 0 up to 336*K-1 and then returns to 0, one step per clock.
- R4: `hsync_n` is 0 exactly while running with `col` below 2*K.
- R5: `line` advances by one each time `col` wraps, counts 0 to 243, and returns to 0 after line 243.
- R6: `vsync_n` is 0 exactly while running on line 0 with `col` below 2*K, giving a pulse of 2*K ticks once per frame of 336*K*244 ticks.
- R7: `de` is 1 exactly while running on lines 2 to 241 with `col` from 7*K+C up to 7*K+C+320*K-1.
- R8: The mode input is captured while idle and at the clock where line 243 wraps to line 0; a change at any other time has no effect until that frame boundary.
- R9: On the first clock edge that samples `en` high after idle, the generator shows `col`=0 and `line`=0 with both syncs asserted, and counts from there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Run enable; low holds the generator idle |
| mode | input | 2 | Bus mode select (0: 16-bit, 1: 8-bit 565, 2: 8-bit 888, 3: as 0) |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| de | output | 1 | Active data window |
| line | output | 8 | Current line, 0 to 243 |
| col | output | 10 | Current tick within the line, 0 to 336*K-1 |

## Verification
The embedded assertions watch on every cycle that idle forces all outputs inactive, that a vertical sync only occurs inside a horizontal sync, that the data window never overlaps horizontal sync, that the column wraps and the line steps at the right edge, and that the captured mode stays put inside a frame. Exact pulse widths, the per-mode window edges, the 244-line frame length and the deferral of a mode change until the frame boundary are shown only by the bench, which compares every output on every cycle against a model built from the requirements across a full frame in mode 0, a mid-frame switch to mode 1, and restarts in modes 2 and 3.

// File: rtl/lcd_raster_timer.sv
module lcd_raster_timer #(
  parameter int ACT_PIX   = 320,
  parameter int LINE_PIX  = 336,
  parameter int SYNC_PIX  = 2,
  parameter int LEAD_PIX  = 7,
  parameter int ACT_LINES = 240,
  parameter int TOP_BLANK = 2,
  parameter int BOT_BLANK = 2,
  parameter int MAX_K     = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic [1:0] mode,
  output logic       hsync_n,
  output logic       vsync_n,
  output logic       de,
  output logic [7:0] line,
  output logic [9:0] col
);
  localparam int TOTAL_LINES = TOP_BLANK + ACT_LINES + BOT_BLANK;
  localparam int LAST_LINE   = TOTAL_LINES - 1;
  localparam int FIRST_ACT   = TOP_BLANK;
  localparam int LAST_ACT    = TOP_BLANK + ACT_LINES - 1;
  localparam int CW          = 10;

  logic       run;
  logic [1:0] mode_r;
  logic [CW-1:0] k, corr, h_last, hs_end, act_beg, act_end;

  always_comb begin
    case (mode_r)
      2'd1:    begin k = CW'(2); corr = CW'(3); end
      2'd2:    begin k = CW'(3); corr = CW'(5); end
      default: begin k = CW'(1); corr = CW'(0); end
    endcase
  end

  assign h_last  = CW'(LINE_PIX) * k - CW'(1);
  assign hs_end  = CW'(SYNC_PIX) * k;
  assign act_beg = CW'(LEAD_PIX) * k + corr;
  assign act_end = act_beg + CW'(ACT_PIX) * k;

  wire col_wrap   = (col == h_last);
  wire frame_wrap = col_wrap && (line == 8'(LAST_LINE));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run    <= 1'b0;
      col    <= '0;
      line   <= '0;
      mode_r <= '0;
    end else if (!en) begin
      run    <= 1'b0;
      col    <= '0;
      line   <= '0;
      mode_r <= mode;
    end else if (!run) begin
      run    <= 1'b1;
      col    <= '0;
      line   <= '0;
      mode_r <= mode;
    end else if (col_wrap) begin
      col <= '0;
      if (frame_wrap) begin
        line   <= '0;
        mode_r <= mode;
      end else begin
        line <= line + 8'd1;
      end
    end else begin
      col <= col + CW'(1);
    end
  end

  wire in_hs = run && (col < hs_end);
  assign hsync_n = ~in_hs;
  assign vsync_n = ~(in_hs && (line == 8'd0));
  assign de = run && (line >= 8'(FIRST_ACT)) && (line <= 8'(LAST_ACT)) &&
              (col >= act_beg) && (col < act_end);

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> (hsync_n && vsync_n && !de && col == '0 && line == '0));

  // R6
  vs_inside_hs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !vsync_n |-> !hsync_n);

  // R7
  de_clear_of_hs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    de |-> hsync_n);

  // R3
  col_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && en && col_wrap) |=> (col == '0));

  // R5
  line_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && en && col_wrap && line != 8'(LAST_LINE)) |=> (line == $past(line) + 8'd1));

  // R8
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && (col != '0 || line != '0)) |-> $stable(mode_r));

  initial assert (MAX_K * LINE_PIX < (1 << CW)) else $error("column width too small");
endmodule

// File: tb/lcd_raster_timer_test.sv
module lcd_raster_timer_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic [1:0] mode = 2'd0;
  logic hsync_n, vsync_n, de;
  logic [7:0] line;
  logic [9:0] col;

  always #2 clk = ~clk;

  lcd_raster_timer uut (.clk(clk), .rst_n(rst_n), .en(en), .mode(mode),
    .hsync_n(hsync_n), .vsync_n(vsync_n), .de(de), .line(line), .col(col));

  typedef struct { logic hs, vs, d; int ln, cl; } exp_t;
  exp_t q[$];
  int checks = 0, failures = 0, cycles = 0;
  string phase = "R1 reset";

  // independent raster model
  bit m_run = 0; int m_col = 0, m_line = 0, m_mode = 0;
  function automatic int kof(int m); return (m == 1) ? 2 : (m == 2) ? 3 : 1; endfunction
  function automatic int cof(int m); return (m == 1) ? 3 : (m == 2) ? 5 : 0; endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin m_run = 0; m_col = 0; m_line = 0; m_mode = 0; end
    else if (!en) begin m_run = 0; m_col = 0; m_line = 0; m_mode = mode; end
    else if (!m_run) begin m_run = 1; m_col = 0; m_line = 0; m_mode = mode; end
    else if (m_col == 336 * kof(m_mode) - 1) begin
      m_col = 0;
      if (m_line == 243) begin m_line = 0; m_mode = mode; end
      else m_line = m_line + 1;
    end else m_col = m_col + 1;
  end

  task automatic push_expected();
    exp_t e; int k, st;
    k = kof(m_mode); st = 7 * k + cof(m_mode);
    e.cl = m_col; e.ln = m_line;
    e.hs = !(m_run && m_col < 2 * k);
    e.vs = !(m_run && m_line == 0 && m_col < 2 * k);
    e.d  = m_run && m_line >= 2 && m_line <= 241 && m_col >= st && m_col < st + 320 * k;
    q.push_back(e);
  endtask

  task automatic cmp(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      if (failures < 20)
        $display("FAIL %s [%s] cycle %0d: actual=%0d expected=%0d", tag, phase, cycles, act, exp);
    end
  endtask

  always @(negedge clk) push_expected();

  always @(negedge clk) begin
    exp_t e;
    #1;
    if (q.size() > 0) begin
      e = q.pop_front();
      cmp("R3 col", int'(col), e.cl);
      cmp("R5 line", int'(line), e.ln);
      cmp("R4 hsync_n", int'(hsync_n), int'(e.hs));
      cmp("R6 vsync_n", int'(vsync_n), int'(e.vs));
      cmp("R7 de", int'(de), int'(e.d));
    end
  end

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 200000) begin
      failures++;
      $display("FAIL watchdog: actual=%0d expected<=200000 cycles", cycles);
      finish_run();
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    phase = "R1 idle";
    repeat (10) @(negedge clk);
    mode = 2'd1;                 // R1 mode change while idle shows nothing
    repeat (5) @(negedge clk);
    mode = 2'd0;
    @(negedge clk);
    phase = "R9 enable start";
    en = 1'b1;
    repeat (50) @(negedge clk);
    phase = "R8 mid-frame mode change";
    mode = 2'd1;                 // must wait for frame boundary
    repeat (336 * 244 + 3 * 672) @(negedge clk);
    phase = "R1 disable";
    en = 1'b0;
    repeat (5) @(negedge clk);
    phase = "R2 mode 2";
    mode = 2'd2;
    @(negedge clk);
    en = 1'b1;
    repeat (3 * 1008 + 40) @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    phase = "R2 mode 3 as mode 0";
    mode = 2'd3;
    @(negedge clk);
    en = 1'b1;
    repeat (3 * 336 + 20) @(negedge clk);
    phase = "R1 reset mid-run";
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule